// File: doc/BRIEF.md
# Compressed Sample Block Stream Sequencer

This block steps one sound voice through a stream of 16-byte compressed sample blocks held in a large sample memory. It keeps the voice's start, loop and current block addresses, all counted in 16-bit words. It also keeps a phase accumulator with a 16-bit fraction. Every sample tick adds an increment derived from the pitch. Each whole unit of phase moves the voice on by one sample, and a block holds 28 samples. When a block is used up, the sequencer reads the next block's flag byte (its second byte) through a single-outstanding valid/ready read port. It then acts on the flag byte: it can mark the loop point, repeat from the loop point, or end the voice, and it raises the voice's end status and an address-match interrupt. The sample decoder and the envelope lie outside this block.

The controller has four states. ST_IDLE is the silent voice. ST_RUN adds phase and consumes samples one per cycle. ST_REQ presents a block read and holds it until the read is accepted. ST_WAIT waits for the flag byte. The transitions are these. Key-on moves ST_IDLE or ST_RUN to ST_RUN with a fresh start. Key-off moves ST_RUN to ST_IDLE. A finished block moves ST_RUN to ST_REQ, or to ST_IDLE if the voice was told to end. An accepted read moves ST_REQ to ST_WAIT. The flag response moves ST_WAIT to ST_RUN, or to ST_IDLE if a key-off came during the fetch.

Top module: `vsq_stream_seq`

## Requirements
- R1: After reset the voice is off, no read is requested, and the end bit and interrupt output are both 0.
- R2: A pitch write stores min(value, 0x3FFF), and the phase increment is that pitch shifted left by 4, or 1 when the pitch is 0. Each sample tick adds one increment to the phase, and each 0x10000 of phase consumes one sample.
- R3: Key-on loads the current address from the start address, sets the phase to 0x10000 with the block marked used up so that a read of the start block follows at once, and clears the end bit. Key-on wins over a key-off in the same cycle.
- R4: After a block's flag byte has been taken, 27 more samples are consumed. The next sample step then reads the following block at the current address plus 8 words, unless R6 applies.
- R5: Flag bit 2 sets the loop address to the address of the block just read, unless the host has written a nonzero loop address since the last key-on. A host loop write locks the loop address when its result is nonzero and unlocks it when the result is zero.
- R6: A flag byte exactly equal to 0x03 makes the next read come from the loop address.
- R7: A flag byte with bit 0 set and a value other than 0x03 lets the voice play out that block. The voice then switches off at the step where the next read would have been made, and no read is issued.
- R8: Flag bit 0 sets the end bit, seen one cycle after the response. A pulse on the end-clear input clears it, and a set in the same cycle as a clear wins.
- R9: When the interrupt is enabled, a one-cycle interrupt pulse follows a response if the interrupt address lies within the 8 words of the block just read. It also follows if flag bit 0 is set and the address lies within the 8 words at the loop address, where the loop address includes any update by this same flag byte.
- R10: The read request stays asserted with a stable address until it is accepted. Only one read is outstanding, and no new request is made while a response is awaited.
- R11: Key-off switches a running voice off at once. If a read is pending, the read and its response complete first, with the flag effects applied, and the voice then switches off.
- R12: The start and loop addresses are 22 bits, written as a 6-bit high half and a 16-bit low half through separate write strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pitch_we | input | 1 | Pitch write strobe |
| pitch_wdata | input | 16 | Pitch value, clamped to 0x3FFF |
| start_hi_we | input | 1 | Write start address bits 21:16 from addr_wdata[5:0] |
| start_lo_we | input | 1 | Write start address bits 15:0 |
| loop_hi_we | input | 1 | Write loop address bits 21:16 from addr_wdata[5:0] |
| loop_lo_we | input | 1 | Write loop address bits 15:0 |
| addr_wdata | input | 16 | Address write data |
| key_on | input | 1 | Start the voice |
| key_off | input | 1 | Stop the voice |
| sample_tick | input | 1 | Adds one phase increment |
| end_clr | input | 1 | Clears the end bit |
| irq_en | input | 1 | Interrupt match enable |
| irq_addr | input | 22 | Interrupt word address |
| rd_valid | output | 1 | Block read request |
| rd_addr | output | 22 | Word address of the block to read |
| rd_ready | input | 1 | Read request accepted |
| rsp_valid | input | 1 | Flag byte valid |
| rsp_flags | input | 8 | Flag byte of the block |
| voice_on | output | 1 | Voice is playing |
| end_bit | output | 1 | End status |
| irq_pulse | output | 1 | One-cycle interrupt |
| cur_addr | output | 22 | Current block address |

## Verification
The end bit and the interrupt pulse are registered at the edge that takes the response, so the bench samples them at the next falling edge and no later. A key-on or a tick shows up in the read port within about eight cycles: one cycle to note the tick, one to add the phase, one per sample step, then the request. The bench therefore waits for a request with a bounded timeout, and when a reference model predicts no read, it watches twelve cycles of silence before it checks the voice state. The request address, the hold of the address while not ready, the end bit and the interrupt are each compared with the model at those fixed points.

// File: rtl/vsq_pkg.sv
package vsq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_REQ,
        ST_WAIT
    } vsq_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_OFF,
        CMD_ON
    } vsq_cmd_e;

    localparam int unsigned FLAG_END_IDX  = 0;
    localparam int unsigned FLAG_MARK_IDX = 2;
    localparam logic [7:0]  FLAG_REPEAT   = 8'h03;
endpackage

// File: rtl/vsq_pitch_step.sv
module vsq_pitch_step #(
    parameter int PITCH_W = 14,
    parameter int IN_W    = 16,
    parameter int SHIFT   = 4,
    parameter int INC_W   = PITCH_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IN_W-1:0]  wdata,
    output logic [INC_W-1:0] inc
);
    localparam logic [IN_W-1:0] PMAX = IN_W'((1 << PITCH_W) - 1);

    logic [PITCH_W-1:0] pitch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pitch_q <= '0;
        end else if (we) begin
            pitch_q <= (wdata > PMAX) ? PMAX[PITCH_W-1:0] : wdata[PITCH_W-1:0];
        end
    end

    always_comb begin
        if (pitch_q == '0) begin
            inc = INC_W'(1);
        end else begin
            inc = {pitch_q, {SHIFT{1'b0}}};
        end
    end

    AST_INC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        inc != '0); // R2
    AST_PITCH_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata > PMAX) |=> inc == {PMAX[PITCH_W-1:0], {SHIFT{1'b0}}}); // R2
endmodule

// File: rtl/vsq_addr_bank.sv
module vsq_addr_bank #(
    parameter int ADDR_W = 22,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_hi_we,
    input  logic              start_lo_we,
    input  logic              loop_hi_we,
    input  logic              loop_lo_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              hw_loop_set,
    input  logic [ADDR_W-1:0] hw_loop_addr,
    input  logic              restart,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] loop_addr,
    output logic              loop_lock
);
    localparam int HI_W = ADDR_W - WORD_W;

    logic [ADDR_W-1:0] start_q, start_nx;
    logic [ADDR_W-1:0] loop_q, loop_host_nx;
    logic              lock_q;
    logic              loop_host_wr;

    always_comb begin
        start_nx = start_q;
        if (start_hi_we) start_nx[ADDR_W-1:WORD_W] = wdata[HI_W-1:0];
        if (start_lo_we) start_nx[WORD_W-1:0]      = wdata;
        loop_host_nx = loop_q;
        if (loop_hi_we) loop_host_nx[ADDR_W-1:WORD_W] = wdata[HI_W-1:0];
        if (loop_lo_we) loop_host_nx[WORD_W-1:0]      = wdata;
    end

    assign loop_host_wr = loop_hi_we | loop_lo_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            loop_q  <= '0;
            lock_q  <= 1'b0;
        end else begin
            start_q <= start_nx;
            if (loop_host_wr) begin
                loop_q <= loop_host_nx;
                lock_q <= (loop_host_nx != '0);
            end else begin
                if (hw_loop_set && !lock_q) loop_q <= hw_loop_addr;
                if (restart) lock_q <= 1'b0;
            end
        end
    end

    assign start_addr = start_q;
    assign loop_addr  = loop_q;
    assign loop_lock  = lock_q;

    AST_LOCK_HOLDS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !loop_host_wr) |=> $stable(loop_q)); // R5
    AST_LOCK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_host_wr && loop_host_nx != '0) |=> lock_q); // R5
endmodule

// File: rtl/vsq_win_hit.sv
module vsq_win_hit #(
    parameter int ADDR_W = 22,
    parameter int SPAN   = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] probe,
    output logic              hit
);
    logic [ADDR_W-1:0] diff;

    assign diff = probe - base;
    assign hit  = diff < ADDR_W'(SPAN);
endmodule

// File: rtl/vsq_stream_seq.sv
module vsq_stream_seq
    import vsq_pkg::*;
#(
    parameter int ADDR_W          = 22,
    parameter int WORD_W          = 16,
    parameter int PITCH_W         = 14,
    parameter int STEP_SHIFT      = 4,
    parameter int FRAC_W          = 16,
    parameter int SAMPLES_PER_BLK = 28,
    parameter int BLK_WORDS       = 8,
    parameter int FLAG_W          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pitch_we,
    input  logic [WORD_W-1:0] pitch_wdata,
    input  logic              start_hi_we,
    input  logic              start_lo_we,
    input  logic              loop_hi_we,
    input  logic              loop_lo_we,
    input  logic [WORD_W-1:0] addr_wdata,
    input  logic              key_on,
    input  logic              key_off,
    input  logic              sample_tick,
    input  logic              end_clr,
    input  logic              irq_en,
    input  logic [ADDR_W-1:0] irq_addr,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic              rsp_valid,
    input  logic [FLAG_W-1:0] rsp_flags,
    output logic              voice_on,
    output logic              end_bit,
    output logic              irq_pulse,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int INC_W = PITCH_W + STEP_SHIFT;
    localparam int PH_W  = ((INC_W > FRAC_W) ? INC_W : FRAC_W) + 2;
    localparam int SB_W  = $clog2(SAMPLES_PER_BLK + 1);
    localparam logic [PH_W-1:0]   PH_ONE  = PH_W'(1) << FRAC_W;
    localparam logic [SB_W-1:0]   SB_FULL = SB_W'(SAMPLES_PER_BLK);
    localparam logic [ADDR_W-1:0] BLK_INC = ADDR_W'(BLK_WORDS);

    vsq_state_e        state_q, state_d;
    vsq_cmd_e          cmd_q, cmd_eff;
    logic [ADDR_W-1:0] cur_q;
    logic [SB_W-1:0]   sb_q;
    logic [PH_W-1:0]   ph_q;
    logic              tick_pend_q;
    logic              stop_pend_q;
    logic              end_q;
    logic              irq_q;

    logic [INC_W-1:0]  inc;
    logic [ADDR_W-1:0] start_addr, loop_addr, loop_eff;
    logic              loop_lock;
    logic              rsp_take, start_take, step_due, blk_over;
    logic              flag_end, flag_mark, flag_repeat;
    logic              hit_blk, hit_loop;

    vsq_pitch_step #(
        .PITCH_W(PITCH_W), .IN_W(WORD_W), .SHIFT(STEP_SHIFT), .INC_W(INC_W)
    ) u_pitch (
        .clk(clk), .rst_n(rst_n), .we(pitch_we), .wdata(pitch_wdata), .inc(inc)
    );

    vsq_addr_bank #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W)
    ) u_addr (
        .clk(clk), .rst_n(rst_n),
        .start_hi_we(start_hi_we), .start_lo_we(start_lo_we),
        .loop_hi_we(loop_hi_we), .loop_lo_we(loop_lo_we),
        .wdata(addr_wdata),
        .hw_loop_set(rsp_take && flag_mark), .hw_loop_addr(cur_q),
        .restart(start_take),
        .start_addr(start_addr), .loop_addr(loop_addr), .loop_lock(loop_lock)
    );

    vsq_win_hit #(.ADDR_W(ADDR_W), .SPAN(BLK_WORDS)) u_hit_blk (
        .base(cur_q), .probe(irq_addr), .hit(hit_blk)
    );

    vsq_win_hit #(.ADDR_W(ADDR_W), .SPAN(BLK_WORDS)) u_hit_loop (
        .base(loop_eff), .probe(irq_addr), .hit(hit_loop)
    );

    // decoded conditions
    assign flag_end    = rsp_flags[FLAG_END_IDX];
    assign flag_mark   = rsp_flags[FLAG_MARK_IDX];
    assign flag_repeat = (rsp_flags == FLAG_REPEAT);
    assign loop_eff    = (flag_mark && !loop_lock) ? cur_q : loop_addr;
    assign rsp_take    = (state_q == ST_WAIT) && rsp_valid;
    assign step_due    = (state_q == ST_RUN) && (ph_q >= PH_ONE);
    assign blk_over    = (sb_q == SB_FULL);

    always_comb begin
        if (key_on)       cmd_eff = CMD_ON;
        else if (key_off) cmd_eff = CMD_OFF;
        else              cmd_eff = cmd_q;
    end

    assign start_take = (key_on && (state_q == ST_IDLE || state_q == ST_RUN))
                     || (rsp_take && cmd_eff == CMD_ON);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (key_on) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (key_on)                    state_d = ST_RUN;
                else if (key_off)              state_d = ST_IDLE;
                else if (step_due && blk_over) state_d = stop_pend_q ? ST_IDLE : ST_REQ;
            end
            ST_REQ: begin
                if (rd_ready) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) state_d = (cmd_eff == CMD_OFF) ? ST_IDLE : ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            sb_q        <= '0;
            ph_q        <= '0;
            tick_pend_q <= 1'b0;
            stop_pend_q <= 1'b0;
            cmd_q       <= CMD_NONE;
            end_q       <= 1'b0;
            irq_q       <= 1'b0;
        end else begin
            // commands arriving while a read is in flight
            if ((state_q == ST_REQ || state_q == ST_WAIT) && !rsp_take) begin
                cmd_q <= cmd_eff;
            end else begin
                cmd_q <= CMD_NONE;
            end

            // tick bookkeeping
            if (start_take || state_q == ST_IDLE) begin
                tick_pend_q <= 1'b0;
            end else if (sample_tick) begin
                tick_pend_q <= 1'b1;
            end else if (state_q == ST_RUN && !step_due) begin
                tick_pend_q <= 1'b0;
            end

            // position and address
            if (start_take) begin
                cur_q <= start_addr;
                sb_q  <= SB_FULL;
                ph_q  <= PH_ONE;
            end else if (rsp_take) begin
                cur_q <= flag_repeat ? loop_eff : (cur_q + BLK_INC);
                sb_q  <= SB_W'(1);
                ph_q  <= ph_q - PH_ONE;
            end else if (state_q == ST_RUN) begin
                if (step_due) begin
                    if (!blk_over) begin
                        sb_q <= sb_q + SB_W'(1);
                        ph_q <= ph_q - PH_ONE;
                    end
                end else if (tick_pend_q) begin
                    ph_q <= ph_q + PH_W'(inc);
                end
            end

            // deferred stop after an end flag
            if (start_take) begin
                stop_pend_q <= 1'b0;
            end else if (rsp_take && flag_end && !flag_repeat) begin
                stop_pend_q <= 1'b1;
            end

            // end status
            if (start_take) begin
                end_q <= 1'b0;
            end else if (rsp_take && flag_end) begin
                end_q <= 1'b1;
            end else if (end_clr) begin
                end_q <= 1'b0;
            end

            irq_q <= rsp_take && irq_en && (hit_blk || (flag_end && hit_loop));
        end
    end

    // outputs
    always_comb begin
        rd_valid  = (state_q == ST_REQ);
        rd_addr   = cur_q;
        voice_on  = (state_q != ST_IDLE);
        end_bit   = end_q;
        irq_pulse = irq_q;
        cur_addr  = cur_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R10
    AST_KEYON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (key_on && (state_q == ST_IDLE || state_q == ST_RUN))
            |=> (voice_on && cur_addr == $past(start_addr) && !end_bit)); // R3
    AST_END_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_take && flag_end && cmd_eff != CMD_ON) |=> end_bit); // R8
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(rsp_take && irq_en)); // R9
    AST_SB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sb_q <= SB_FULL); // R4
    AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pend_q && step_due && blk_over && !key_on) |=> (!voice_on && !rd_valid)); // R7
endmodule

// File: tb/vsq_stream_seq_test.sv
module vsq_stream_seq_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 22;
    localparam logic [AW-1:0] AMASK = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pitch_we = 0, start_hi_we = 0, start_lo_we = 0;
    logic          loop_hi_we = 0, loop_lo_we = 0;
    logic [15:0]   pitch_wdata = '0, addr_wdata = '0;
    logic          key_on = 0, key_off = 0, sample_tick = 0, end_clr = 0, irq_en = 0;
    logic [AW-1:0] irq_addr = '0;
    logic          rd_valid, rd_ready = 0, rsp_valid = 0;
    logic [AW-1:0] rd_addr, cur_addr;
    logic [7:0]    rsp_flags = '0;
    logic          voice_on, end_bit, irq_pulse;

    always #2 clk = ~clk;

    vsq_stream_seq uut (
        .clk(clk), .rst_n(rst_n), .pitch_we(pitch_we), .pitch_wdata(pitch_wdata),
        .start_hi_we(start_hi_we), .start_lo_we(start_lo_we),
        .loop_hi_we(loop_hi_we), .loop_lo_we(loop_lo_we), .addr_wdata(addr_wdata),
        .key_on(key_on), .key_off(key_off), .sample_tick(sample_tick),
        .end_clr(end_clr), .irq_en(irq_en), .irq_addr(irq_addr),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rsp_valid(rsp_valid), .rsp_flags(rsp_flags),
        .voice_on(voice_on), .end_bit(end_bit), .irq_pulse(irq_pulse),
        .cur_addr(cur_addr)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic [AW-1:0] m_cur, m_loop, m_start;
    logic          m_lock = 0, m_stop = 0, m_active = 0, m_end = 0;
    int            m_sb = 0, m_ph = 0, m_inc = 1;
    logic [7:0]    ftab [64];
    bit            koff_in_fetch = 0, clr_with_rsp = 0;
    string         addr_tag = "R4 R5 R6 fetch address";

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] flags_of(input logic [AW-1:0] a);
        return ftab[(a >> 3) & 63];
    endfunction

    function automatic bit in_win(input logic [AW-1:0] probe, input logic [AW-1:0] base);
        logic [AW-1:0] d;
        d = (probe - base) & AMASK;
        return d < 8;
    endfunction

    function automatic int pitch_inc(input logic [15:0] v);
        int p;
        p = (v > 16'h3FFF) ? 32'h3FFF : int'(v);
        return (p == 0) ? 1 : (p << 4);
    endfunction

    task automatic serve_fetch();
        int w;
        int d;
        logic [7:0]    f;
        logic [AW-1:0] blk;
        bit            exp_irq;
        w = 0;
        while (!rd_valid && w < 40) begin
            @(negedge clk);
            w++;
        end
        chk(rd_valid, "R4 read request due", 32'(rd_valid), 1);
        chk(rd_addr == m_cur, addr_tag, 32'(rd_addr), 32'(m_cur));
        addr_tag = "R4 R5 R6 fetch address";
        d = $urandom_range(0, 2);
        for (int i = 0; i < d; i++) begin
            @(negedge clk);
            chk(rd_valid && rd_addr == m_cur, "R10 request held", 32'(rd_addr), 32'(m_cur));
        end
        rd_ready = 1;
        if (koff_in_fetch) key_off = 1;
        @(negedge clk);
        rd_ready = 0;
        key_off = 0;
        chk(!rd_valid, "R10 single outstanding", 32'(rd_valid), 0);
        d = $urandom_range(0, 2);
        for (int i = 0; i < d; i++) @(negedge clk);
        blk = m_cur;
        f = flags_of(blk);
        if (f[2] && !m_lock) m_loop = blk;
        exp_irq = irq_en && (in_win(irq_addr, blk) || (f[0] && in_win(irq_addr, m_loop)));
        if (f[0]) m_end = 1;
        else if (clr_with_rsp) m_end = 0;
        if (f == 8'h03) m_cur = m_loop;
        else m_cur = (blk + 8) & AMASK;
        if (f[0] && f != 8'h03) m_stop = 1;
        rsp_valid = 1;
        rsp_flags = f;
        end_clr = clr_with_rsp;
        @(negedge clk);
        rsp_valid = 0;
        end_clr = 0;
        chk(irq_pulse == exp_irq, "R9 interrupt pulse", 32'(irq_pulse), 32'(exp_irq));
        chk(end_bit == m_end, "R8 end bit after flags", 32'(end_bit), 32'(m_end));
        if (koff_in_fetch) m_active = 0;
    endtask

    task automatic run_model();
        while (m_active && m_ph >= 65536) begin
            if (m_sb == 28) begin
                if (m_stop) begin
                    m_active = 0;
                    break;
                end
                serve_fetch();
                m_sb = 0;
                if (!m_active) break;
            end
            m_sb++;
            m_ph -= 65536;
        end
        repeat (12) @(negedge clk);
        chk(!rd_valid, "R2 no unexpected read", 32'(rd_valid), 0);
        chk(voice_on == m_active, "R7 R11 voice state", 32'(voice_on), 32'(m_active));
    endtask

    task automatic write_pitch(input logic [15:0] v);
        @(negedge clk);
        pitch_we = 1; pitch_wdata = v;
        @(negedge clk);
        pitch_we = 0;
        m_inc = pitch_inc(v);
    endtask

    task automatic write_start(input logic [AW-1:0] a);
        @(negedge clk);
        start_hi_we = 1; addr_wdata = 16'(a >> 16);
        @(negedge clk);
        start_hi_we = 0; start_lo_we = 1; addr_wdata = a[15:0];
        @(negedge clk);
        start_lo_we = 0;
        m_start = a;
    endtask

    task automatic write_loop(input logic [AW-1:0] a);
        @(negedge clk);
        loop_lo_we = 1; addr_wdata = a[15:0];
        @(negedge clk);
        loop_lo_we = 0; loop_hi_we = 1; addr_wdata = 16'(a >> 16);
        @(negedge clk);
        loop_hi_we = 0;
        m_loop = a;
        m_lock = (a != 0);
    endtask

    task automatic do_keyon(input bit with_off);
        @(negedge clk);
        key_on = 1; key_off = with_off;
        @(negedge clk);
        key_on = 0; key_off = 0;
        chk(end_bit == 0, "R3 end bit cleared by key-on", 32'(end_bit), 0);
        chk(voice_on == 1, "R3 voice on after key-on", 32'(voice_on), 1);
        m_cur = m_start; m_sb = 28; m_ph = 65536;
        m_stop = 0; m_lock = 0; m_end = 0; m_active = 1;
        addr_tag = "R3 R12 first read at start address";
        run_model();
    endtask

    task automatic do_tick();
        @(negedge clk);
        sample_tick = 1;
        @(negedge clk);
        sample_tick = 0;
        if (m_active) m_ph += m_inc;
        run_model();
    endtask

    task automatic do_clear();
        @(negedge clk);
        end_clr = 1;
        @(negedge clk);
        end_clr = 0;
        m_end = 0;
        chk(end_bit == 0, "R8 end bit cleared", 32'(end_bit), 0);
    endtask

    task automatic do_keyoff();
        @(negedge clk);
        key_off = 1;
        @(negedge clk);
        key_off = 0;
        chk(voice_on == 0, "R11 key-off stops voice", 32'(voice_on), 0);
        m_active = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd5171));
        for (int i = 0; i < 64; i++) begin
            case ($urandom_range(0, 15))
                8, 9:    ftab[i] = 8'h04;
                10:      ftab[i] = 8'h02;
                11:      ftab[i] = 8'h03;
                12:      ftab[i] = 8'h43;
                13:      ftab[i] = 8'h01;
                14:      ftab[i] = 8'h07;
                15:      ftab[i] = 8'h06;
                default: ftab[i] = 8'h00;
            endcase
        end
        m_loop = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(voice_on == 0, "R1 reset voice off", 32'(voice_on), 0);
        chk(rd_valid == 0, "R1 reset no read", 32'(rd_valid), 0);
        chk(end_bit == 0, "R1 reset end bit", 32'(end_bit), 0);
        chk(irq_pulse == 0, "R1 reset interrupt", 32'(irq_pulse), 0);

        // directed: pitch zero gives the minimum increment, no progress
        write_pitch(16'h0000);
        write_start(22'h2A_1230);
        do_keyon(1'b1);
        for (int i = 0; i < 10; i++) do_tick();
        // directed: clamp an oversized pitch and run
        write_pitch(16'hFFFF);
        for (int i = 0; i < 30 && m_active; i++) do_tick();
        do_keyoff();

        // directed: loop lock, key-off during a fetch, clear racing a set
        write_pitch(16'h2000);
        write_start(22'h01_0000);
        irq_en = 1;
        irq_addr = 22'h01_0004;
        do_keyon(1'b0);
        write_loop(22'h01_0040);
        for (int i = 0; i < 40 && m_active; i++) do_tick();
        clr_with_rsp = 1;
        for (int i = 0; i < 40 && m_active; i++) do_tick();
        clr_with_rsp = 0;
        koff_in_fetch = 1;
        for (int i = 0; i < 60 && m_active; i++) do_tick();
        koff_in_fetch = 0;
        if (m_active) do_keyoff();

        // constrained random episodes
        for (int e = 0; e < 12; e++) begin
            logic [AW-1:0] s;
            s = AW'($urandom) & AMASK & ~AW'(7);
            write_pitch(16'($urandom_range(16'h1000, 16'h4FFF)));
            write_start(s);
            irq_en = $urandom_range(0, 1);
            irq_addr = (s + AW'($urandom_range(0, 80))) & AMASK;
            do_keyon(1'b0);
            if ($urandom_range(0, 2) == 0) write_loop(($urandom_range(0, 1) == 0) ? '0 : (s + 22'h18));
            for (int t = 0; t < 150 && m_active; t++) begin
                koff_in_fetch = ($urandom_range(0, 29) == 0);
                clr_with_rsp  = ($urandom_range(0, 9) == 0);
                if ($urandom_range(0, 39) == 0) do_clear();
                if ($urandom_range(0, 99) == 0) begin
                    do_keyoff();
                end else begin
                    do_tick();
                end
            end
            koff_in_fetch = 0;
            clr_with_rsp = 0;
            if (m_active) do_keyoff();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule